// File: doc/BRIEF.md
# USB Host Root Port Control and Status

This block holds the control and status state of one root port on a USB host. Software drives it through single-cycle write strobes, each with a data bit: one starts a bus reset, one asks for suspend, and one controls the force-resume bit. Software reads back the power, enable, suspend and reset bits and the current bus line state. On the bus side the block samples the D+ and D− levels and a flag that marks a transaction in progress. It drives two outputs: a request to hold SE0 on the bus while a reset runs, and a signal that stops downstream traffic while the port is suspended.

The block times the bus reset itself and clears the reset bit when the reset ends, so software never has to clear it. When software asks for suspend during a transaction, the request is held and takes effect once the bus goes idle. In device mode the reset and suspend bits are status only, and software writes to them change nothing.

Top module: `usbp_port_ctl`

## Requirements
- R1: `st_line` shows `{dp_in, dm_in}` after `SYNC_STAGES` clock edges. D+ is the upper bit, and the codes are 00 for SE0, 01 for J, 10 for K and 11 for undefined.
- R2: In host mode with power on, a reset write with data 1 raises `st_reset` and `drive_se0` on the next cycle. Both stay high for exactly `RST_CYCLES` cycles and then return to 0 with no action from software. A reset write with data 0 has no effect.
- R3: When a reset completes, `st_enable` reads 1 and `st_suspend` reads 0.
- R4: A reset started while the port is suspended clears `st_suspend` and `block_ds` on the next cycle, and the reset runs to completion.
- R5: A suspend write with data 1 to an enabled port while `xfer_busy` is 0 sets `st_suspend` and `block_ds` on the next cycle.
- R6: A suspend write with data 1 while `xfer_busy` is 1 leaves `st_suspend` at 0 as long as `xfer_busy` stays high. Suspend takes effect on the cycle after `xfer_busy` falls.
- R7: A suspend write with data 0 is ignored. A force-resume write with data 0 clears `st_suspend` and `block_ds` on the next cycle.
- R8: A suspend write while `st_enable` is 0 is ignored.
- R9: While `host_mode` is 0, reset writes and suspend writes are ignored.
- R10: While `port_power` is 0, `st_reset` and `st_suspend` read 0 and `drive_se0` is 0. Any reset in progress aborts, and enable, suspend and reset are all 0 from the next cycle on.
- R11: `block_ds` is 1 exactly when the port is in the suspended state (enable 1, suspend 1), and suspend is never 1 while enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mode | input | 1 | 1 selects host mode, 0 selects device mode |
| port_power | input | 1 | Port power bit |
| wr_reset | input | 1 | Write strobe for the reset bit |
| wr_reset_val | input | 1 | Data bit for the reset write |
| wr_susp | input | 1 | Write strobe for the suspend bit |
| wr_susp_val | input | 1 | Data bit for the suspend write |
| wr_fres | input | 1 | Write strobe for the force-resume bit |
| wr_fres_val | input | 1 | Data bit for the force-resume write |
| dp_in | input | 1 | Sampled D+ level |
| dm_in | input | 1 | Sampled D− level |
| xfer_busy | input | 1 | A transaction is in progress on the bus |
| st_enable | output | 1 | Port enable status |
| st_suspend | output | 1 | Port suspend status |
| st_reset | output | 1 | Port reset status |
| st_line | output | 2 | Line state, D+ in bit 1 |
| drive_se0 | output | 1 | Request to hold SE0 on the bus |
| block_ds | output | 1 | Blocks downstream traffic |

## Verification
The bench builds the block with `RST_CYCLES` set to 12 and `SYNC_STAGES` set to 2. The short reset count lets the bench check every cycle of a complete reset, a reset aborted by power loss, and a reset started from suspend, all in a short run. With two sync stages the bench can check the two-edge delay on the line state for all four codes.

// File: rtl/usbp_pkg.sv
package usbp_pkg;

   typedef enum logic [1:0] {
      LS_SE0   = 2'b00,
      LS_J     = 2'b01,
      LS_K     = 2'b10,
      LS_UNDEF = 2'b11
   } line_state_e;

   typedef enum logic [1:0] {
      PST_DISABLED  = 2'b00,
      PST_ENABLED   = 2'b01,
      PST_SUSPENDED = 2'b11
   } port_state_e;

   typedef struct packed {
      logic rst_start;
      logic susp_req;
      logic susp_clr;
   } port_cmd_t;

   function automatic port_state_e port_state(input logic en, input logic sus);
      if (!en)     return PST_DISABLED;
      else if (sus) return PST_SUSPENDED;
      else         return PST_ENABLED;
   endfunction

endpackage

// File: rtl/usbp_line_sync.sv
module usbp_line_sync
   import usbp_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        dp,
   input  logic        dm,
   output line_state_e line_o
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("usbp_line_sync: STAGES must lie in 0..4");
   end

   logic [1:0] raw;
   assign raw = {dp, dm};

   if (STAGES == 0) begin : g_direct
      assign line_o = line_state_e'(raw);
   end else begin : g_chain
      logic [1:0] stg_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= 2'b00;
         end else begin
            stg_q[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end
      assign line_o = line_state_e'(stg_q[STAGES-1]);
   end

endmodule

// File: rtl/usbp_cmd_decode.sv
module usbp_cmd_decode
   import usbp_pkg::*;
(
   input  logic      host_mode,
   input  logic      pwr,
   input  logic      rst_active,
   input  logic      en,
   input  logic      sus,
   input  logic      wr_reset,
   input  logic      wr_reset_val,
   input  logic      wr_susp,
   input  logic      wr_susp_val,
   input  logic      wr_fres,
   input  logic      wr_fres_val,
   output port_cmd_t cmd_o
);

   logic host_ok;
   assign host_ok = host_mode && pwr;

   always_comb begin
      cmd_o = '0;
      if (host_ok) begin
         // zero writes to reset are dropped; the timer owns clearing
         cmd_o.rst_start = wr_reset && wr_reset_val && !rst_active;
         // suspend only from the enabled state; zero writes dropped
         cmd_o.susp_req  = wr_susp && wr_susp_val && en && !sus && !rst_active;
         cmd_o.susp_clr  = wr_fres && !wr_fres_val;
      end
   end

endmodule

// File: rtl/usbp_reset_timer.sv
module usbp_reset_timer #(
   parameter int RST_CYCLES = 500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr,
   input  logic start,
   output logic active_o,
   output logic done_o
);

   if (RST_CYCLES < 2) begin : g_bad_len
      $error("usbp_reset_timer: RST_CYCLES must be at least 2");
   end

   localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

   logic          active_q;
   logic [CW-1:0] cnt_q;

   assign active_o = active_q;
   assign done_o   = active_q && pwr && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!pwr) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= LOAD;
      end else if (active_q) begin
         if (cnt_q == '0) active_q <= 1'b0;
         else             cnt_q    <= cnt_q - 1'b1;
      end
   end

   // independent length tracker for the checks
   logic [CW:0] seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_q <= '0;
      else if (start)    seen_q <= (CW+1)'(1);
      else if (active_q) seen_q <= seen_q + 1'b1;
   end

   AST_RST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (seen_q <= (CW+1)'(RST_CYCLES)));  // R2
   AST_RST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (seen_q == (CW+1)'(RST_CYCLES)));     // R2
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> !start);                            // R2
   AST_PWR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr |=> !active_q);                             // R10

endmodule

// File: rtl/usbp_suspend_ctl.sv
module usbp_suspend_ctl
   import usbp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr,
   input  logic      busy,
   input  port_cmd_t cmd,
   input  logic      rst_done,
   output logic      en_o,
   output logic      sus_o
);

   logic en_q, sus_q, pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         sus_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (!pwr) begin
         en_q   <= 1'b0;
         sus_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (cmd.rst_start) begin
         en_q   <= 1'b0;
         sus_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (rst_done) begin
         en_q   <= 1'b1;
         sus_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (cmd.susp_clr) begin
         sus_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (cmd.susp_req) begin
         if (busy) pend_q <= 1'b1;
         else      sus_q  <= 1'b1;
      end else if (pend_q && !busy) begin
         sus_q  <= 1'b1;
         pend_q <= 1'b0;
      end
   end

   assign en_o  = en_q;
   assign sus_o = sus_q;

   AST_SUSP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      sus_q |-> en_q);                                     // R11
   AST_SUSP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sus_q) |-> !$past(busy));                      // R6
   AST_DONE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_done && pwr) |=> (en_q && !sus_q));             // R3
   AST_RST_CLEARS_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.rst_start && pwr) |=> !sus_q);                  // R4
   AST_PWR_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr |=> (!en_q && !sus_q && !pend_q));              // R10

endmodule

// File: rtl/usbp_port_ctl.sv
module usbp_port_ctl
   import usbp_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int RST_MS      = 10,
   parameter int RST_CYCLES  = (CLK_HZ / 1000) * RST_MS,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_mode,
   input  logic       port_power,
   input  logic       wr_reset,
   input  logic       wr_reset_val,
   input  logic       wr_susp,
   input  logic       wr_susp_val,
   input  logic       wr_fres,
   input  logic       wr_fres_val,
   input  logic       dp_in,
   input  logic       dm_in,
   input  logic       xfer_busy,
   output logic       st_enable,
   output logic       st_suspend,
   output logic       st_reset,
   output logic [1:0] st_line,
   output logic       drive_se0,
   output logic       block_ds
);

   line_state_e line_s;
   port_cmd_t   cmd;
   logic        rst_active, rst_done, en_s, sus_s;
   port_state_e pst;

   usbp_line_sync #(.STAGES(SYNC_STAGES)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .dp     (dp_in),
      .dm     (dm_in),
      .line_o (line_s)
   );

   usbp_cmd_decode u_dec (
      .host_mode    (host_mode),
      .pwr          (port_power),
      .rst_active   (rst_active),
      .en           (en_s),
      .sus          (sus_s),
      .wr_reset     (wr_reset),
      .wr_reset_val (wr_reset_val),
      .wr_susp      (wr_susp),
      .wr_susp_val  (wr_susp_val),
      .wr_fres      (wr_fres),
      .wr_fres_val  (wr_fres_val),
      .cmd_o        (cmd)
   );

   usbp_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr      (port_power),
      .start    (cmd.rst_start),
      .active_o (rst_active),
      .done_o   (rst_done)
   );

   usbp_suspend_ctl u_sus (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr      (port_power),
      .busy     (xfer_busy),
      .cmd      (cmd),
      .rst_done (rst_done),
      .en_o     (en_s),
      .sus_o    (sus_s)
   );

   assign pst        = port_state(en_s, sus_s);
   assign st_enable  = en_s;
   assign st_suspend = sus_s && port_power;
   assign st_reset   = rst_active && port_power;
   assign st_line    = line_s;
   assign drive_se0  = rst_active && port_power;
   assign block_ds   = (pst == PST_SUSPENDED);

   AST_SE0_ONLY_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      drive_se0 |-> port_power);                          // R10
   AST_NO_BLOCK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      drive_se0 |-> !block_ds);                           // R4

endmodule

// File: tb/usbp_port_ctl_tb.sv
module usbp_port_ctl_tb_top;

   localparam int RSTC = 12;
   localparam int F_EN = 0, F_SUS = 1, F_RST = 2, F_SE0 = 3, F_BLK = 4, F_LINE = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_mode = 1'b1, port_power = 1'b1;
   logic wr_reset = 0, wr_reset_val = 0, wr_susp = 0, wr_susp_val = 0;
   logic wr_fres = 0, wr_fres_val = 0, dp_in = 0, dm_in = 0, xfer_busy = 0;
   logic st_enable, st_suspend, st_reset, drive_se0, block_ds;
   logic [1:0] st_line;

   always #10 clk = ~clk;

   usbp_port_ctl #(.RST_CYCLES(RSTC), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .port_power(port_power),
      .wr_reset(wr_reset), .wr_reset_val(wr_reset_val),
      .wr_susp(wr_susp), .wr_susp_val(wr_susp_val),
      .wr_fres(wr_fres), .wr_fres_val(wr_fres_val),
      .dp_in(dp_in), .dm_in(dm_in), .xfer_busy(xfer_busy),
      .st_enable(st_enable), .st_suspend(st_suspend), .st_reset(st_reset),
      .st_line(st_line), .drive_se0(drive_se0), .block_ds(block_ds)
   );

   typedef struct {
      string req;
      int    fld;
      int    exp;
   } item_t;

   item_t q[$];
   item_t it;
   int    n_checks = 0;
   int    n_fail = 0;
   int    act;
   bit    finished = 0;

   // monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         it = q.pop_front();
         case (it.fld)
            F_EN:    act = int'(st_enable);
            F_SUS:   act = int'(st_suspend);
            F_RST:   act = int'(st_reset);
            F_SE0:   act = int'(drive_se0);
            F_BLK:   act = int'(block_ds);
            default: act = int'(st_line);
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s field=%0d actual=%0d expected=%0d", it.req, it.fld, act, it.exp);
         end
      end
   end

   task automatic expect_f(input int fld, input int val, input string req);
      item_t e;
      e.req = req; e.fld = fld; e.exp = val;
      q.push_back(e);
   endtask

   task automatic step();
      @(posedge clk);
   endtask

   task automatic go();
      @(negedge clk);
      #1;
   endtask

   task automatic idle_strobes();
      wr_reset = 0; wr_susp = 0; wr_fres = 0;
   endtask

   // single-cycle write pulses; the state after capture is checked by the caller
   task automatic pulse_reset(input logic v);
      wr_reset = 1; wr_reset_val = v; step(); go(); idle_strobes();
   endtask

   task automatic pulse_susp(input logic v);
      wr_susp = 1; wr_susp_val = v; step(); go(); idle_strobes();
   endtask

   task automatic pulse_fres(input logic v);
      wr_fres = 1; wr_fres_val = v; step(); go(); idle_strobes();
   endtask

   // runs a full reset from the write and checks every cycle of it
   task automatic full_reset(input string req);
      wr_reset = 1; wr_reset_val = 1;
      step();
      expect_f(F_SE0, 1, req); expect_f(F_RST, 1, req);
      go(); idle_strobes();
      for (int k = 2; k <= RSTC; k++) begin
         step(); expect_f(F_SE0, 1, req); go();
      end
      step();
      expect_f(F_SE0, 0, req); expect_f(F_RST, 0, req);
      expect_f(F_EN, 1, "R3"); expect_f(F_SUS, 0, "R3");
      go();
   endtask

   task automatic check_line(input logic p, input logic m);
      dp_in = p; dm_in = m;
      step(); go();
      step(); expect_f(F_LINE, int'({p, m}), "R1"); go();
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      go(); go();
      rst_n = 1;
      step();
      expect_f(F_EN, 0, "R11"); expect_f(F_SUS, 0, "R11");
      expect_f(F_RST, 0, "R2"); expect_f(F_SE0, 0, "R2"); expect_f(F_BLK, 0, "R11");
      go();

      // R1 line codes
      check_line(0, 1); check_line(1, 0); check_line(1, 1); check_line(0, 0);

      // R8 suspend on a disabled port
      wr_susp = 1; wr_susp_val = 1; step();
      expect_f(F_SUS, 0, "R8"); expect_f(F_BLK, 0, "R8"); go(); idle_strobes();

      // R2 zero write to reset ignored, then a full reset
      wr_reset = 1; wr_reset_val = 0; step();
      expect_f(F_SE0, 0, "R2"); expect_f(F_RST, 0, "R2"); go(); idle_strobes();
      full_reset("R2");

      // R5 suspend when idle
      wr_susp = 1; wr_susp_val = 1; step();
      expect_f(F_SUS, 1, "R5"); expect_f(F_BLK, 1, "R5"); go(); idle_strobes();

      // R7 zero write to suspend ignored, force-resume zero clears
      wr_susp = 1; wr_susp_val = 0; step();
      expect_f(F_SUS, 1, "R7"); go(); idle_strobes();
      wr_fres = 1; wr_fres_val = 0; step();
      expect_f(F_SUS, 0, "R7"); expect_f(F_BLK, 0, "R7"); expect_f(F_EN, 1, "R7");
      go(); idle_strobes();

      // R6 suspend deferred while busy
      xfer_busy = 1;
      wr_susp = 1; wr_susp_val = 1; step();
      expect_f(F_SUS, 0, "R6"); expect_f(F_BLK, 0, "R6"); go(); idle_strobes();
      for (int k = 0; k < 3; k++) begin
         step(); expect_f(F_SUS, 0, "R6"); go();
      end
      xfer_busy = 0;
      step(); expect_f(F_SUS, 1, "R6"); expect_f(F_BLK, 1, "R6"); go();

      // R4 reset from suspend
      wr_reset = 1; wr_reset_val = 1; step();
      expect_f(F_SUS, 0, "R4"); expect_f(F_BLK, 0, "R4"); expect_f(F_SE0, 1, "R4");
      go(); idle_strobes();
      for (int k = 2; k <= RSTC; k++) begin
         step(); expect_f(F_SE0, 1, "R4"); go();
      end
      step(); expect_f(F_SE0, 0, "R4"); expect_f(F_EN, 1, "R4"); go();

      // R9 device mode ignores writes
      host_mode = 0;
      pulse_reset(1);
      step(); expect_f(F_RST, 0, "R9"); expect_f(F_SE0, 0, "R9"); go();
      pulse_susp(1);
      step(); expect_f(F_SUS, 0, "R9"); expect_f(F_BLK, 0, "R9"); go();
      host_mode = 1;

      // R10 power loss from suspend
      pulse_susp(1);
      step(); expect_f(F_SUS, 1, "R10"); go();
      port_power = 0;
      step();
      expect_f(F_EN, 0, "R10"); expect_f(F_SUS, 0, "R10"); expect_f(F_BLK, 0, "R10");
      go();
      pulse_reset(1);
      step(); expect_f(F_RST, 0, "R10"); expect_f(F_SE0, 0, "R10"); go();
      port_power = 1;
      step(); expect_f(F_EN, 0, "R10"); expect_f(F_RST, 0, "R10"); go();

      // R10 power loss aborts a running reset
      pulse_reset(1);
      for (int k = 0; k < 3; k++) begin step(); go(); end
      step(); expect_f(F_SE0, 1, "R10"); go();
      port_power = 0;
      step(); expect_f(F_SE0, 0, "R10"); expect_f(F_RST, 0, "R10"); go();
      port_power = 1;
      for (int k = 0; k < RSTC + 2; k++) begin
         step(); expect_f(F_SE0, 0, "R10"); expect_f(F_EN, 0, "R10"); go();
      end

      // R3 a second full reset still enables
      full_reset("R2");

      go();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule